// File: doc/BRIEF.md
# Ring-Oscillator Thermal Sensor Sequencer

This block runs an array of on-die ring-oscillator temperature sensors from the system clock. Each oscillator output enters as an asynchronous input, and the block drives a separate enable back to each oscillator. On every sweep the sensors are visited one at a time in ascending index order. The selected oscillator is switched on and allowed to settle with no edges counted. Its rising edges are then counted over a fixed gate window, and at the end of that window it is switched off. Because each oscillator draws power only inside its own short window, self-heating stays low. No two sensors ever run together, so a sensor never measures heat produced by its neighbours.

A new sweep starts at a fixed slow period derived from the clock. Each sensor's result is held in its own record, made of a saturating edge count and a sticky overflow flag. A one-cycle done pulse marks the end of a sweep. Software or a test controller captures every record at once into a serial shift chain and clocks the records out one bit per cycle. The conversion of counts to temperature happens outside this block.

Top module: `rosc_thermal_seq`

## Requirements
- R1: At most one bit of `osc_en_o` is high at any time. Within a sweep the enables follow index order 0, 1, …, N_SENS-1, and each enable is followed directly by the next one (or by all-low after the last).
- R2: Each enable stays high for exactly SETTLE_CYC + GATE_CYC clock cycles and then drops.
- R3: Rising edges that occur during the first SETTLE_CYC cycles of a sensor's enable are not counted. Edges on the inputs of sensors that are not selected are never counted.
- R4: A sensor's count equals the number of rising edges on its input that fall inside its gate window. The input must stay high for at least two clock cycles and low for at least two clock cycles.
- R5: The count saturates at 2^CNT_W-1. If a further edge arrives at that value, the record's overflow flag is set. Reaching the maximum alone does not set the flag. Both the count and the flag are cleared at the start of each gate window.
- R6: The enable of sensor 0 rises exactly PERIOD_CYC cycles after reset is released, and then every PERIOD_CYC cycles.
- R7: `done_o` is high for exactly one cycle per sweep. That cycle is the one in which the last sensor's enable has just dropped, so all enables are low when it is high.
- R8: `scan_load_i` copies all records into the chain and takes priority over `scan_shift_i`. `scan_shift_i` moves the chain one bit per clock toward `scan_out_o`, filling with zeros. With neither input high, the chain holds its value. The output order is sensor 0's record first. Each record is N_SENS-independent and CNT_W+1 bits long: the overflow flag comes first, then the count, most significant bit first.
- R9: A synchronous reset drops every enable and `done_o` on the next cycle, clears all records and the chain, and makes the sequencer wait for a full period (R6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_i | input | N_SENS | Ring-oscillator outputs, asynchronous, one per sensor |
| osc_en_o | output | N_SENS | Oscillator enables, at most one high |
| done_o | output | 1 | One-cycle pulse at the end of each sweep |
| scan_load_i | input | 1 | Capture all records into the shift chain |
| scan_shift_i | input | 1 | Shift the chain one bit toward the output |
| scan_out_o | output | 1 | Serial data output of the chain |

## Verification
The bench builds the block with four sensors and a 4-bit count. It uses a settle time of 8 cycles, a gate time of 100 cycles and a period of 600 cycles. These values make a full sweep take a few hundred cycles, so several sweeps, a mid-sweep reset and the period spacing all fit easily in the run. The small count width lets a gate window hold more edges than the counter can represent. This brings the exact-maximum case and the saturation-with-overflow case within reach. The 20-bit chain is short enough to read out completely after every sweep.

// File: rtl/rts_pkg.sv
package rts_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_GATE   = 2'd2
    } rts_state_e;

endpackage

// File: rtl/rts_period_timer.sv
module rts_period_timer #(
    parameter int PERIOD_CYC = 25_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic start_o
);
    localparam int PW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;

    logic [PW-1:0] pcnt_d, pcnt_q;

    always_comb begin
        start_o = (pcnt_q == PW'(PERIOD_CYC - 1));
        pcnt_d  = start_o ? '0 : pcnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pcnt_q <= '0;
        else     pcnt_q <= pcnt_d;
    end
endmodule

// File: rtl/rts_edge_sync.sv
module rts_edge_sync #(
    parameter int N_SENS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SENS-1:0] osc_i,
    output logic [N_SENS-1:0] rise_o
);
    for (genvar g = 0; g < N_SENS; g++) begin : g_lane
        logic [2:0] pipe_d, pipe_q;

        always_comb begin
            pipe_d    = {pipe_q[1:0], osc_i[g]};
            rise_o[g] = pipe_q[1] & ~pipe_q[2];
        end

        always_ff @(posedge clk) begin
            if (rst) pipe_q <= '0;
            else     pipe_q <= pipe_d;
        end
    end
endmodule

// File: rtl/rts_scan_chain.sv
module rts_scan_chain #(
    parameter int N_SENS = 32,
    parameter int REC_W  = 17
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load_i,
    input  logic                         shift_i,
    input  logic [N_SENS-1:0][REC_W-1:0] par_i,
    output logic                         ser_o
);
    localparam int TOT_W = N_SENS * REC_W;

    logic [TOT_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (load_i) begin
            for (int s = 0; s < N_SENS; s++) begin
                chain_d[TOT_W-1-s*REC_W -: REC_W] = par_i[s];
            end
        end else if (shift_i) begin
            chain_d = {chain_q[TOT_W-2:0], 1'b0};
        end
        ser_o = chain_q[TOT_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end
endmodule

// File: rtl/rosc_thermal_seq.sv
module rosc_thermal_seq
    import rts_pkg::*;
#(
    parameter int N_SENS     = 32,
    parameter int CNT_W      = 16,
    parameter int SETTLE_CYC = 20_000,
    parameter int GATE_CYC   = 400_000,
    parameter int PERIOD_CYC = 25_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SENS-1:0] osc_i,
    output logic [N_SENS-1:0] osc_en_o,
    output logic              done_o,
    input  logic              scan_load_i,
    input  logic              scan_shift_i,
    output logic              scan_out_o
);
    localparam int REC_W  = CNT_W + 1;
    localparam int SEL_W  = (N_SENS > 1) ? $clog2(N_SENS) : 1;
    localparam int T_MAX  = (SETTLE_CYC > GATE_CYC) ? SETTLE_CYC : GATE_CYC;
    localparam int TCNT_W = $clog2(T_MAX + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        rts_state_e                   state;
        logic [SEL_W-1:0]             sel;
        logic [TCNT_W-1:0]            tcnt;
        logic [CNT_W-1:0]             cnt;
        logic                         ovf;
        logic                         done;
        logic [N_SENS-1:0][REC_W-1:0] res;
    } seq_t;

    seq_t        seq_d, seq_q;
    logic        start;
    logic [N_SENS-1:0] rise;

    rts_period_timer #(.PERIOD_CYC(PERIOD_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start_o (start)
    );

    rts_edge_sync #(.N_SENS(N_SENS)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .osc_i  (osc_i),
        .rise_o (rise)
    );

    rts_scan_chain #(.N_SENS(N_SENS), .REC_W(REC_W)) u_scan (
        .clk     (clk),
        .rst     (rst),
        .load_i  (scan_load_i),
        .shift_i (scan_shift_i),
        .par_i   (seq_q.res),
        .ser_o   (scan_out_o)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (start) begin
                    seq_d.state = ST_SETTLE;
                    seq_d.sel   = '0;
                    seq_d.tcnt  = '0;
                end
            end
            ST_SETTLE: begin
                if (seq_q.tcnt == TCNT_W'(SETTLE_CYC - 1)) begin
                    seq_d.state = ST_GATE;
                    seq_d.tcnt  = '0;
                    seq_d.cnt   = '0;
                    seq_d.ovf   = 1'b0;
                end else begin
                    seq_d.tcnt = seq_q.tcnt + 1'b1;
                end
            end
            ST_GATE: begin
                if (rise[seq_q.sel]) begin
                    if (seq_q.cnt == CNT_MAX) seq_d.ovf = 1'b1;
                    else                      seq_d.cnt = seq_q.cnt + 1'b1;
                end
                if (seq_q.tcnt == TCNT_W'(GATE_CYC - 1)) begin
                    seq_d.res[seq_q.sel] = {seq_d.ovf, seq_d.cnt};
                    seq_d.tcnt           = '0;
                    if (seq_q.sel == SEL_W'(N_SENS - 1)) begin
                        seq_d.state = ST_IDLE;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.sel   = seq_q.sel + 1'b1;
                        seq_d.state = ST_SETTLE;
                    end
                end else begin
                    seq_d.tcnt = seq_q.tcnt + 1'b1;
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= '0;
        else     seq_q <= seq_d;
    end

    always_comb begin
        osc_en_o = '0;
        if (seq_q.state != ST_IDLE) osc_en_o[seq_q.sel] = 1'b1;
        done_o = seq_q.done;
    end
endmodule

// File: rtl/rts_checker.sv
module rts_checker #(
    parameter int N_SENS = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [N_SENS-1:0] osc_en_o,
    input logic              done_o,
    input logic              scan_load_i,
    input logic              scan_shift_i,
    input logic              scan_out_o
);
    AST_EN_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(osc_en_o)); // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R7

    AST_DONE_EN_LOW: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (osc_en_o == '0)); // R7

    AST_SCAN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!scan_load_i && !scan_shift_i) |=> $stable(scan_out_o)); // R8

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (osc_en_o == '0) && !done_o && !scan_out_o); // R9
endmodule

bind rosc_thermal_seq rts_checker #(.N_SENS(N_SENS)) u_rts_checker (
    .clk          (clk),
    .rst          (rst),
    .osc_en_o     (osc_en_o),
    .done_o       (done_o),
    .scan_load_i  (scan_load_i),
    .scan_shift_i (scan_shift_i),
    .scan_out_o   (scan_out_o)
);

// File: tb/rosc_thermal_seq_bench.sv
module rosc_thermal_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam int CW         = 4;
    localparam int SETTLE     = 8;
    localparam int GATE       = 100;
    localparam int PERIOD     = 600;
    localparam int REC_W      = CW + 1;
    localparam int TOT        = N * REC_W;
    localparam int CMAX       = (1 << CW) - 1;

    logic           clk = 1'b0;
    logic           rst;
    logic [N-1:0]   osc;
    logic [N-1:0]   en;
    logic           done;
    logic           load, shift;
    logic           sout;

    int checks = 0;
    int fails  = 0;
    longint cyc = 0;

    rosc_thermal_seq #(
        .N_SENS(N), .CNT_W(CW), .SETTLE_CYC(SETTLE),
        .GATE_CYC(GATE), .PERIOD_CYC(PERIOD)
    ) u_rosc_thermal_seq (
        .clk(clk), .rst(rst), .osc_i(osc), .osc_en_o(en), .done_o(done),
        .scan_load_i(load), .scan_shift_i(shift), .scan_out_o(sout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: enable order and length, period spacing, done pulse.
    logic [N-1:0] prev_en = '0;
    int     run = 0;
    longint last_rise = 0;
    bit     have_rise = 0;
    bit     prev_done = 0;
    int     done_cnt = 0;

    always @(negedge clk) begin
        if (rst) begin
            prev_en = '0; run = 0; have_rise = 0; prev_done = 0;
        end else begin
            if ($countones(en) > 1) chk(0, "R1 onehot", longint'(en), 0);
            if (done) begin
                done_cnt++;
                chk(en == '0 && prev_en == (N)'(1 << (N-1)), "R7 done timing",
                    longint'(prev_en), longint'(1 << (N-1)));
                chk(!prev_done, "R7 done width", 2, 1);
            end
            prev_done = done;
            if (en[0] && !prev_en[0]) begin
                if (have_rise) chk(cyc - last_rise == PERIOD, "R6 period",
                                   cyc - last_rise, PERIOD);
                last_rise = cyc; have_rise = 1;
            end
            if (en != prev_en) begin
                if (prev_en != '0) begin
                    chk(run == SETTLE + GATE, "R2 enable length", run, SETTLE + GATE);
                    if (en == '0) chk(prev_en == (N)'(1 << (N-1)), "R1 order end",
                                      longint'(prev_en), longint'(1 << (N-1)));
                    else          chk(en == (prev_en << 1), "R1 order",
                                      longint'(en), longint'(prev_en << 1));
                end
                run = 1;
            end else if (en != '0) begin
                run++;
            end
            prev_en = en;
        end
    end

    task automatic scan_read(input bit both_first, input int hold, output logic [TOT-1:0] v);
        @(negedge clk); load = 1'b1; shift = both_first;
        @(negedge clk); load = 1'b0; shift = 1'b0;
        v[TOT-1] = sout;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(sout == v[TOT-1], "R8 hold", sout, v[TOT-1]);
        end
        shift = 1'b1;
        for (int b = TOT - 2; b >= 0; b--) begin
            @(negedge clk);
            v[b] = sout;
        end
        shift = 1'b0;
    endtask

    task automatic drive_sensor(input int i, input int k);
        int nb = (i + 1) % N;
        while (!en[i]) @(negedge clk);
        // one edge during settling: must be ignored (R3)
        osc[i] = 1'b1; repeat (2) @(negedge clk);
        osc[i] = 1'b0; repeat (SETTLE + 2) @(negedge clk);
        for (int p = 0; p < k; p++) begin
            osc[i] = 1'b1; osc[nb] = 1'b1; repeat (2) @(negedge clk);
            osc[i] = 1'b0; osc[nb] = 1'b0; repeat (2) @(negedge clk);
        end
    endtask

    task automatic t_sweep(input int k0, input int k1, input int k2, input int k3,
                           input bit both_first, input int hold);
        int k[N];
        int d0;
        logic [TOT-1:0] got, exp;
        k = '{k0, k1, k2, k3};
        d0 = done_cnt;
        for (int i = 0; i < N; i++) drive_sensor(i, k[i]);
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(done_cnt == d0 + 1, "R7 one done per sweep", done_cnt - d0, 1);
        for (int s = 0; s < N; s++) begin
            exp[TOT-1-s*REC_W -: REC_W] = {k[s] > CMAX ? 1'b1 : 1'b0,
                                           CW'(k[s] > CMAX ? CMAX : k[s])};
        end
        scan_read(both_first, hold, got);
        for (int s = 0; s < N; s++) begin
            chk(got[TOT-1-s*REC_W -: REC_W] == exp[TOT-1-s*REC_W -: REC_W],
                (k[s] > CMAX) ? "R5 saturate" : "R4 R3 R8 count",
                got[TOT-1-s*REC_W -: REC_W], exp[TOT-1-s*REC_W -: REC_W]);
        end
    endtask

    task automatic t_reset_start;
        logic [TOT-1:0] got;
        longint c0;
        chk(en == '0, "R9 reset enables", en, 0);
        chk(!done, "R9 reset done", done, 0);
        rst = 1'b0; c0 = cyc;
        scan_read(1'b0, 0, got);
        chk(got == '0, "R9 records cleared", got, 0);
        while (!en[0]) @(negedge clk);
        chk(cyc - c0 == PERIOD, "R6 first start", cyc - c0, PERIOD);
    endtask

    task automatic t_reset_mid;
        logic [TOT-1:0] got;
        longint c0;
        while (!en[2]) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(en == '0, "R9 mid reset enables", en, 0);
        chk(!done, "R9 mid reset done", done, 0);
        rst = 1'b0; c0 = cyc;
        scan_read(1'b0, 0, got);
        chk(got == '0, "R9 mid reset records", got, 0);
        while (!en[0]) @(negedge clk);
        chk(cyc - c0 == PERIOD, "R6 restart after reset", cyc - c0, PERIOD);
    endtask

    initial begin
        rst = 1'b1; osc = '0; load = 1'b0; shift = 1'b0;
        repeat (3) @(negedge clk);
        t_reset_start();
        t_sweep(3, 0, 15, 20, 1'b0, 0);
        t_sweep(7, 1, 2, 9, 1'b1, 4);
        t_reset_mid();
        t_sweep(12, 5, 16, 4, 1'b0, 2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule